// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates three interrupt sources for a small processor core: a falling edge on an external request pin, a timer overflow pulse, and an end-of-conversion pulse from an analogue front end. It holds one 8-bit control/flag register that software can read and write. The register carries a master enable, an enable for each source and a pending flag for each source.

Once per instruction cycle the core raises a sample strobe. On that strobe the controller picks the highest-priority source that is pending and enabled. It does so only when the master enable is set and the return stack still has room. It then issues a one-cycle acknowledge carrying the source's entry address. In the same step it clears that source's flag and the master enable, so the service routine cannot be interrupted.

A return-from-interrupt strobe sets the master enable again. A plain return strobe leaves it as it is. The program counter, the stack storage and the core itself live outside this block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and `ack` is 0 with `ack_vec` at 0.
- R2: A write with `reg_we` loads the register from `reg_wdata`. Bit 7 is reserved and always reads 0. The layout is: bit0 master enable, bit1 pin enable, bit2 timer enable, bit3 conversion enable, bit4 pin flag, bit5 timer flag, bit6 conversion flag.
- R3: A high-to-low change of `ext_pin` sets bit4 at the next clock edge. A pin that stays low, or that rises, sets nothing.
- R4: A one-cycle `tmr_ovf` pulse sets bit5 and a `cvt_done` pulse sets bit6. Flags are recorded whatever the enable bits hold, and stay set until serviced or overwritten by a write.
- R5: An acknowledge requires four things in the same cycle: `smp_stb` high, bit0 set, at least one source with both its flag and its enable set, and `stk_full` low. `ack` rises in the cycle after that strobe cycle. `ack_vec` is 11 bits wide and holds 0x004 for the pin, 0x008 for the timer and 0x00C for conversion.
- R6: When several enabled sources are pending, the pin wins over the timer and the timer wins over conversion. A pending source whose enable is clear is passed over.
- R7: The clock edge that raises `ack` also clears bit0 and the serviced source's flag, and leaves every other flag as it was. `ack` lasts exactly one cycle.
- R8: While `stk_full` is high, no acknowledge occurs and the pending flag stays set. The request is acknowledged on the first strobe after `stk_full` falls.
- R9: A `reti_stb` pulse sets bit0. A `ret_stb` pulse leaves bit0 unchanged. If an acknowledge clears bit0 in the same cycle, the clear wins.
- R10: If a hardware event sets a flag in the same cycle as a register write, the flag reads 1 afterwards whatever value was written.
- R11: Without `smp_stb`, no acknowledge is ever issued, even with an enabled pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External request pin; its falling edge raises a request |
| tmr_ovf | input | 1 | Timer overflow pulse |
| cvt_done | input | 1 | Conversion-complete pulse |
| stk_full | input | 1 | Return stack has no free entry |
| smp_stb | input | 1 | Once-per-instruction sample strobe |
| reti_stb | input | 1 | Return-from-interrupt executed |
| ret_stb | input | 1 | Plain subroutine return executed |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ack | output | 1 | Interrupt acknowledge pulse |
| ack_vec | output | 11 | Entry address of the acknowledged source |

## Verification
The bench sets all three flags and enables at once and then walks down the priority chain. A design with the order reversed, or one that clears more than the serviced flag, shows up as a wrong vector or a wrong flag pattern.

It holds a request against a full stack and then releases the stack. A controller that drops the flag, or that acknowledges anyway, fails here.

It also sends a return and a return-from-interrupt to separate their effect on the master enable. It keeps the pin low without a fresh edge to catch level-triggered detection. Finally it collides a hardware flag set with a software write to show which of the two wins.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC    = 3;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int VEC_W   = 11;
    localparam int VEC_STEP = 4;
    localparam int REG_W   = 8;

    // Source index order is also the priority order (0 = highest).
    typedef enum logic [IDX_W-1:0] {
        SRC_PIN  = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_CVT  = 2'd2
    } src_e;

    typedef struct packed {
        logic            rsvd;    // bit7
        logic [NSRC-1:0] flag;    // bits6:4
        logic [NSRC-1:0] en;      // bits3:1
        logic            master;  // bit0
    } ctl_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        v = VEC_W'((int'(idx) + 1) * VEC_STEP);
        return v;
    endfunction

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b1;
        else     pin_q <= pin;
    end

    assign fall = pin_q & ~pin;
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_W-1:0]     wdata,
    input  logic [NSRC-1:0]      hw_set,
    input  logic                 reti,
    input  logic                 ack_clr,
    input  logic [IDX_W-1:0]     ack_idx,
    output ctl_t                 cur
);
    ctl_t nxt;

    always_comb begin
        nxt = cur;
        if (we) nxt = ctl_t'(wdata);
        nxt.rsvd = 1'b0;
        if (reti) nxt.master = 1'b1;
        if (ack_clr) begin
            nxt.master        = 1'b0;
            nxt.flag[ack_idx] = 1'b0;
        end
        // hardware events override writes and service clears
        nxt.flag = nxt.flag | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  ctl_t             cur,
    input  logic             smp,
    input  logic             stk_full,
    output logic             fire,
    output logic [IDX_W-1:0] idx
);
    logic [NSRC-1:0] pend;

    assign pend = cur.flag & cur.en;

    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign fire = smp & cur.master & ~stk_full & (|pend);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic              tmr_ovf,
    input  logic              cvt_done,
    input  logic              stk_full,
    input  logic              smp_stb,
    input  logic              reti_stb,
    input  logic              ret_stb,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              ack,
    output logic [10:0]       ack_vec
);
    logic             pin_fall;
    logic [NSRC-1:0]  hw_set;
    logic             fire;
    logic [IDX_W-1:0] win_idx;
    ctl_t             cur;
    logic             ret_seen;

    irq_pin_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .fall (pin_fall)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[SRC_PIN] = pin_fall;
        hw_set[SRC_TMR] = tmr_ovf;
        hw_set[SRC_CVT] = cvt_done;
    end

    irq_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .hw_set  (hw_set),
        .reti    (reti_stb),
        .ack_clr (fire),
        .ack_idx (win_idx),
        .cur     (cur)
    );

    irq_arbiter u_arb (
        .cur      (cur),
        .smp      (smp_stb),
        .stk_full (stk_full),
        .fire     (fire),
        .idx      (win_idx)
    );

    // a plain return has no effect on the master enable
    assign ret_seen = ret_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            ack_vec <= '0;
        end else begin
            ack <= fire;
            if (fire) ack_vec <= vec_of(win_idx);
        end
    end

    assign reg_rdata = cur;

    logic unused_ok;
    assign unused_ok = ret_seen;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_stb,
    input logic        stk_full,
    input logic        reti_stb,
    input logic [7:0]  reg_rdata,
    input logic        ack,
    input logic [10:0] ack_vec
);
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] == 1'b0);

    a_r5_vec_legal: assert property (@(posedge clk) disable iff (rst)
        ack |-> (ack_vec == 11'h004 || ack_vec == 11'h008 || ack_vec == 11'h00C));

    a_r6_pin_first: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_vec != 11'h004) |-> !($past(reg_rdata[4]) && $past(reg_rdata[1])));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r7_master_clear: assert property (@(posedge clk) disable iff (rst)
        ack |-> !reg_rdata[0]);

    a_r8_stack_hold: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && stk_full) |=> !ack);

    a_r9_reti_sets: assert property (@(posedge clk) disable iff (rst)
        (reti_stb && !smp_stb) |=> reg_rdata[0]);

    a_r11_need_strobe: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> !ack);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .smp_stb   (smp_stb),
    .stk_full  (stk_full),
    .reti_stb  (reti_stb),
    .reg_rdata (reg_rdata),
    .ack       (ack),
    .ack_vec   (ack_vec)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ext_pin, tmr_ovf, cvt_done, stk_full, smp_stb;
    logic        reti_stb, ret_stb, reg_we;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        ack;
    logic [10:0] ack_vec;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .cvt_done(cvt_done), .stk_full(stk_full), .smp_stb(smp_stb),
        .reti_stb(reti_stb), .ret_stb(ret_stb), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack), .ack_vec(ack_vec)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic strobe();
        smp_stb = 1'b1;
        tick();
        smp_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 ack", ack, 0);
        chk("R1 vec", ack_vec, 0);
    endtask

    task automatic t_regrw();
        wr(8'hFF);
        chk("R2 rsvd bit", reg_rdata, 8'h7F);
        wr(8'h0A);
        chk("R2 readback", reg_rdata, 8'h0A);
        wr(8'h00);
    endtask

    task automatic t_pin_edge();
        ext_pin = 1'b0;
        tick();
        chk("R3 fall sets bit4", reg_rdata, 8'h10);
        wr(8'h00);
        tick(); tick();
        chk("R3 steady low", reg_rdata, 8'h00);
        ext_pin = 1'b1;
        tick();
        chk("R3 rise", reg_rdata, 8'h00);
    endtask

    task automatic t_masked();
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
        cvt_done = 1'b1; tick(); cvt_done = 1'b0;
        chk("R4 masked record", reg_rdata, 8'h60);
        strobe();
        chk("R5 no ack when disabled", ack, 0);
        wr(8'h00);
    endtask

    task automatic t_vectors();
        wr(8'h13);
        strobe();
        chk("R5 pin ack", ack, 1);
        chk("R5 pin vec", ack_vec, 11'h004);
        chk("R7 pin clear", reg_rdata, 8'h02);
        tick();
        chk("R7 ack one cycle", ack, 0);
        wr(8'h25);
        strobe();
        chk("R5 tmr vec", ack_vec, 11'h008);
        chk("R7 tmr clear", reg_rdata, 8'h04);
        wr(8'h49);
        strobe();
        chk("R5 cvt vec", ack_vec, 11'h00C);
        chk("R7 cvt clear", reg_rdata, 8'h08);
        tick();
    endtask

    task automatic t_priority();
        wr(8'h7F);
        strobe();
        chk("R6 all -> pin", ack_vec, 11'h004);
        chk("R7 others kept", reg_rdata, 8'h6E);
        wr(8'h6F);
        strobe();
        chk("R6 tmr next", ack_vec, 11'h008);
        chk("R7 cvt kept", reg_rdata, 8'h4E);
        wr(8'h4F);
        strobe();
        chk("R6 cvt last", ack_vec, 11'h00C);
        wr(8'h7D);
        strobe();
        chk("R6 pin disabled skipped", ack_vec, 11'h008);
        chk("R6 pin flag kept", reg_rdata, 8'h5C);
        wr(8'h00);
    endtask

    task automatic t_stack();
        wr(8'h25);
        stk_full = 1'b1;
        strobe();
        chk("R8 no ack when full", ack, 0);
        chk("R8 flag held", reg_rdata, 8'h25);
        stk_full = 1'b0;
        strobe();
        chk("R8 ack after release", ack, 1);
        chk("R8 vec", ack_vec, 11'h008);
        wr(8'h00);
    endtask

    task automatic t_returns();
        ret_stb = 1'b1; tick(); ret_stb = 1'b0;
        chk("R9 ret keeps master", reg_rdata, 8'h00);
        reti_stb = 1'b1; tick(); reti_stb = 1'b0;
        chk("R9 reti sets master", reg_rdata, 8'h01);
        wr(8'h00);
    endtask

    task automatic t_hw_wins();
        tmr_ovf = 1'b1;
        wr(8'h00);
        tmr_ovf = 1'b0;
        chk("R10 hw set beats write", reg_rdata, 8'h20);
        wr(8'h00);
    endtask

    task automatic t_nostrobe();
        wr(8'h25);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11 no strobe no ack", ack, 0);
        end
        chk("R11 flag intact", reg_rdata, 8'h25);
        wr(8'h00);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; ext_pin = 1'b1; tmr_ovf = 0; cvt_done = 0; stk_full = 0;
        smp_stb = 0; reti_stb = 0; ret_stb = 0; reg_we = 0; reg_wdata = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_regrw();
        t_pin_edge();
        t_masked();
        t_vectors();
        t_priority();
        t_stack();
        t_returns();
        t_hw_wins();
        t_nostrobe();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule